// File: doc/BRIEF.md
# Early Load Tracking Table

This block remembers loads that were issued ahead of older stores which might write the same bytes. When such a load is issued, its destination register number and its byte range are written into a small fully associative table. Every store is snooped against all live entries, and any entry whose byte range overlaps the store's byte range is dropped. Later, a check for a register asks whether the entry is still present: a hit means no conflicting store arrived in between and the early value may be used; a miss means the value must be recovered.

Two check forms exist. The branching form asks for a jump to recovery code on a miss. The reload form asks for the value to be loaded again on a miss. Either form may also clear the entry after the lookup. A single-cycle flush drops every entry. Data, the register file, the recovery jump itself and the cache are outside this block.

Each of the 16 slots is a two-state machine. The states are EMPTY and ARMED. The transitions are: allocate (EMPTY to ARMED, or ARMED to ARMED with new contents), snoop kill (ARMED to EMPTY on an overlapping store), check clear (ARMED to EMPTY on a clearing check that hits), and flush (any state to EMPTY). A new load writes, in order of preference, to the slot already holding its register, to the lowest-numbered empty slot, or to a victim slot. A round-robin pointer picks the victim and moves only when it is used.

Top module: `early_load_table`

## Requirements
- R1: After reset, every slot is EMPTY and `chk_done`, `chk_hit`, `recover_req` and `reload_req` are 0. A check issued right after reset misses.
- R2: A load with `ld_valid`=1 and `ld_deferred`=0 arms an entry for `ld_reg`. A check for that register in any later cycle reports `chk_hit`=1, provided nothing removed the entry in between.
- R3: A store removes every armed entry whose byte range overlaps the store's byte range. A range starts at the address and has length 2^size bytes, where size 0,1,2,3 means 1,2,4,8 bytes. Overlap of a single byte is enough.
- R4: A store whose byte range does not overlap an entry, including a store to the byte just past the entry's end, leaves that entry armed.
- R5: `chk_kind`=1 selects the branching form, which reports a miss with `recover_req`=1. `chk_kind`=0 selects the reload form, which reports a miss with `reload_req`=1. A hit raises neither output.
- R6: A check with `chk_clear`=1 reports the lookup result and then removes the matching entry. A check with `chk_clear`=0 leaves the entry armed.
- R7: A new load to a register that already has an entry overwrites that entry's address and size and never creates a second entry for the same register.
- R8: When all slots are armed, a load for a new register replaces a victim. Victims are chosen round-robin, in slot order starting at slot 0 after reset.
- R9: When a store and a check occur in the same cycle, the store's removal is applied first, so the check sees the table after the store.
- R10: A load with `ld_deferred`=1 changes nothing in the table. No entry is created, and an existing entry for the same register keeps its old address.
- R11: `flush_all` empties every slot in one cycle. A check in the same cycle as a flush misses, and a load in the same cycle as a flush is dropped.
- R12: `chk_done` is 1 in exactly the cycle after a cycle with `chk_valid`=1. The result outputs are registered and valid only while `chk_done` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush_all | input | 1 | Drop every entry this cycle |
| ld_valid | input | 1 | Early load issued this cycle |
| ld_deferred | input | 1 | Early load result marked deferred; no entry is made |
| ld_reg | input | REG_W (7) | Destination register of the early load |
| ld_addr | input | ADDR_W (32) | First byte address of the early load |
| ld_size | input | 2 | Log2 of the load's byte count |
| st_valid | input | 1 | Store issued this cycle |
| st_addr | input | ADDR_W (32) | First byte address of the store |
| st_size | input | 2 | Log2 of the store's byte count |
| chk_valid | input | 1 | Check issued this cycle |
| chk_reg | input | REG_W (7) | Register being checked |
| chk_kind | input | 1 | 1 = branching form, 0 = reload form |
| chk_clear | input | 1 | Remove the entry after the lookup |
| chk_done | output | 1 | Check result valid (one cycle after the check) |
| chk_hit | output | 1 | Entry was present |
| recover_req | output | 1 | Branching-form miss |
| reload_req | output | 1 | Reload-form miss |

## Verification
Stores are placed just past an entry's last byte, one byte before it with a two-byte span, and exactly on a reloaded address. This separates an exact range-overlap test from a plain base-address compare, and it shows whether an overwritten entry really moved to its new address. Checks are issued in both forms, with and without clearing. This tells the recovery output apart from the reload output, and it shows whether the clearing lookup still reports the hit it consumed. Combined cycles (a store and a check, a flush and a check) show the order in which same-cycle events are applied. Filling all sixteen slots and then loading two new registers shows which victims the round-robin pointer picks.

// File: rtl/ldt_pkg.sv
package ldt_pkg;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_ARMED = 1'b1
    } slot_state_e;

    typedef enum logic {
        CHK_RELOAD = 1'b0,
        CHK_BRANCH = 1'b1
    } chk_form_e;

    // Two byte spans [base, base + 2**lg - 1] share at least one byte.
    // 65-bit arithmetic keeps the span end from wrapping.
    function automatic logic spans_overlap(
        input logic [63:0] a_base,
        input logic [1:0]  a_lg,
        input logic [63:0] b_base,
        input logic [1:0]  b_lg
    );
        logic [64:0] a_last;
        logic [64:0] b_last;
        a_last = {1'b0, a_base} + (65'(1) << a_lg) - 65'(1);
        b_last = {1'b0, b_base} + (65'(1) << b_lg) - 65'(1);
        return ({1'b0, a_base} <= b_last) && ({1'b0, b_base} <= a_last);
    endfunction

endpackage

// File: rtl/ldt_entry.sv
module ldt_entry
    import ldt_pkg::*;
#(
    parameter int REG_W  = 7,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_reg,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [1:0]        wr_size,
    input  logic              clr_en,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [1:0]        st_size,
    output logic              held,
    output logic [REG_W-1:0]  slot_reg,
    output logic              snoop_kill
);

    slot_state_e       state_q;
    slot_state_e       state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        size_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SLOT_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Payload register: written only by the allocate transition
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_reg <= '0;
            addr_q   <= '0;
            size_q   <= '0;
        end else if (wr_en && !flush) begin
            slot_reg <= wr_reg;
            addr_q   <= wr_addr;
            size_q   <= wr_size;
        end
    end

    // Snoop of the current store against this slot's span
    always_comb begin
        snoop_kill = (state_q == SLOT_ARMED) && st_valid &&
                     spans_overlap(64'(addr_q), size_q, 64'(st_addr), st_size);
    end

    // Transitions: allocate, snoop kill, check clear, flush
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: begin
                if (wr_en && !flush) begin
                    state_d = SLOT_ARMED;
                end
            end
            SLOT_ARMED: begin
                if (flush) begin
                    state_d = SLOT_EMPTY;
                end else if (wr_en) begin
                    state_d = SLOT_ARMED;
                end else if (snoop_kill || clr_en) begin
                    state_d = SLOT_EMPTY;
                end
            end
            default: state_d = SLOT_EMPTY;
        endcase
    end

    // Outputs
    always_comb begin
        held = (state_q == SLOT_ARMED);
    end

endmodule

// File: rtl/ldt_victim_rr.sv
module ldt_victim_rr #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [IDX_W-1:0] ptr
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (advance) begin
            ptr <= (ptr == LAST) ? '0 : ptr + IDX_W'(1);
        end
    end

endmodule

// File: rtl/ldt_alloc_pick.sv
module ldt_alloc_pick #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] held,
    input  logic [ENTRIES-1:0] same_reg,
    input  logic [IDX_W-1:0]   victim,
    output logic [ENTRIES-1:0] sel,
    output logic               use_victim
);

    logic [ENTRIES-1:0] free_vec;
    logic [ENTRIES-1:0] lowest_free;

    always_comb begin
        free_vec    = ~held;
        lowest_free = free_vec & (~free_vec + ENTRIES'(1));
        use_victim  = 1'b0;
        if (|same_reg) begin
            sel = same_reg;
        end else if (|free_vec) begin
            sel = lowest_free;
        end else begin
            sel        = ENTRIES'(1) << victim;
            use_victim = 1'b1;
        end
    end

endmodule

// File: rtl/early_load_table.sv
module early_load_table
    import ldt_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int REG_W   = 7,
    parameter int ADDR_W  = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_all,
    input  logic              ld_valid,
    input  logic              ld_deferred,
    input  logic [REG_W-1:0]  ld_reg,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [1:0]        ld_size,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [1:0]        st_size,
    input  logic              chk_valid,
    input  logic [REG_W-1:0]  chk_reg,
    input  logic              chk_kind,
    input  logic              chk_clear,
    output logic              chk_done,
    output logic              chk_hit,
    output logic              recover_req,
    output logic              reload_req
);

    logic [ENTRIES-1:0] slot_held;
    logic [ENTRIES-1:0] slot_kill;
    logic [ENTRIES-1:0] same_reg;
    logic [ENTRIES-1:0] chk_match;
    logic [ENTRIES-1:0] wr_sel;
    logic [ENTRIES-1:0] clr_sel;
    logic [REG_W-1:0]   slot_reg [ENTRIES];
    logic [IDX_W-1:0]   victim_ptr;
    logic               use_victim;
    logic               alloc_go;
    logic               hit_now;
    chk_form_e          form;

    assign alloc_go = ld_valid && !ld_deferred && !flush_all;
    assign form     = chk_form_e'(chk_kind);

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        assign same_reg[i]  = slot_held[i] && (slot_reg[i] == ld_reg);
        // Lookup sees the table after this cycle's store
        assign chk_match[i] = slot_held[i] && (slot_reg[i] == chk_reg) && !slot_kill[i];
        assign clr_sel[i]   = chk_valid && chk_clear && chk_match[i];

        ldt_entry #(
            .REG_W  (REG_W),
            .ADDR_W (ADDR_W)
        ) u_entry (
            .clk        (clk),
            .rst_n      (rst_n),
            .flush      (flush_all),
            .wr_en      (alloc_go && wr_sel[i]),
            .wr_reg     (ld_reg),
            .wr_addr    (ld_addr),
            .wr_size    (ld_size),
            .clr_en     (clr_sel[i]),
            .st_valid   (st_valid),
            .st_addr    (st_addr),
            .st_size    (st_size),
            .held       (slot_held[i]),
            .slot_reg   (slot_reg[i]),
            .snoop_kill (slot_kill[i])
        );
    end

    ldt_alloc_pick #(
        .ENTRIES (ENTRIES)
    ) u_pick (
        .held       (slot_held),
        .same_reg   (same_reg),
        .victim     (victim_ptr),
        .sel        (wr_sel),
        .use_victim (use_victim)
    );

    ldt_victim_rr #(
        .ENTRIES (ENTRIES)
    ) u_rr (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (alloc_go && use_victim),
        .ptr     (victim_ptr)
    );

    assign hit_now = !flush_all && (|chk_match);

    // Registered check response
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_done    <= 1'b0;
            chk_hit     <= 1'b0;
            recover_req <= 1'b0;
            reload_req  <= 1'b0;
        end else begin
            chk_done    <= chk_valid;
            chk_hit     <= chk_valid && hit_now;
            recover_req <= chk_valid && !hit_now && (form == CHK_BRANCH);
            reload_req  <= chk_valid && !hit_now && (form == CHK_RELOAD);
        end
    end

endmodule

// File: rtl/early_load_table_chk.sv
module early_load_table_chk #(
    parameter int ENTRIES = 16,
    parameter int REG_W   = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic               flush_all,
    input logic               ld_valid,
    input logic               ld_deferred,
    input logic               st_valid,
    input logic               chk_valid,
    input logic               chk_kind,
    input logic               chk_done,
    input logic               chk_hit,
    input logic               recover_req,
    input logic               reload_req,
    input logic [ENTRIES-1:0] slot_held,
    input logic [REG_W-1:0]   slot_reg [ENTRIES]
);

    logic dup_seen;

    always_comb begin
        dup_seen = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            for (int j = i + 1; j < ENTRIES; j++) begin
                if (slot_held[i] && slot_held[j] && (slot_reg[i] == slot_reg[j])) begin
                    dup_seen = 1'b1;
                end
            end
        end
    end

    p_done_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |=> chk_done);

    p_done_only_after_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |=> !chk_done);

    p_flags_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_done |-> !(chk_hit || recover_req || reload_req));

    p_hit_excludes_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
        chk_hit |-> !(recover_req || reload_req));

    p_branch_miss_recovers_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_done && !chk_hit && $past(chk_kind)) |-> (recover_req && !reload_req));

    p_reload_miss_reloads_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_done && !chk_hit && !$past(chk_kind)) |-> (reload_req && !recover_req));

    p_no_duplicate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !dup_seen);

    p_flush_empties_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (slot_held == '0));

    p_flush_check_misses_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && flush_all) |=> !chk_hit);

    p_deferred_inert_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_deferred && !st_valid && !chk_valid && !flush_all)
        |=> (slot_held == $past(slot_held)));

endmodule

bind early_load_table early_load_table_chk #(
    .ENTRIES (ENTRIES),
    .REG_W   (REG_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush_all   (flush_all),
    .ld_valid    (ld_valid),
    .ld_deferred (ld_deferred),
    .st_valid    (st_valid),
    .chk_valid   (chk_valid),
    .chk_kind    (chk_kind),
    .chk_done    (chk_done),
    .chk_hit     (chk_hit),
    .recover_req (recover_req),
    .reload_req  (reload_req),
    .slot_held   (slot_held),
    .slot_reg    (slot_reg)
);

// File: tb/early_load_table_tb.sv
module early_load_table_tb;

    localparam int CLK_PERIOD = 10;
    localparam int REG_W      = 7;
    localparam int ADDR_W     = 32;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              flush_all;
    logic              ld_valid;
    logic              ld_deferred;
    logic [REG_W-1:0]  ld_reg;
    logic [ADDR_W-1:0] ld_addr;
    logic [1:0]        ld_size;
    logic              st_valid;
    logic [ADDR_W-1:0] st_addr;
    logic [1:0]        st_size;
    logic              chk_valid;
    logic [REG_W-1:0]  chk_reg;
    logic              chk_kind;
    logic              chk_clear;
    logic              chk_done;
    logic              chk_hit;
    logic              recover_req;
    logic              reload_req;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    typedef struct {
        logic  hit;
        logic  rec;
        logic  rel;
        string tag;
    } exp_t;

    exp_t sb[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    early_load_table u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_all   (flush_all),
        .ld_valid    (ld_valid),
        .ld_deferred (ld_deferred),
        .ld_reg      (ld_reg),
        .ld_addr     (ld_addr),
        .ld_size     (ld_size),
        .st_valid    (st_valid),
        .st_addr     (st_addr),
        .st_size     (st_size),
        .chk_valid   (chk_valid),
        .chk_reg     (chk_reg),
        .chk_kind    (chk_kind),
        .chk_clear   (chk_clear),
        .chk_done    (chk_done),
        .chk_hit     (chk_hit),
        .recover_req (recover_req),
        .reload_req  (reload_req)
    );

    // Advance one cycle and drop all strobes
    task automatic step();
        @(negedge clk);
        flush_all   = 1'b0;
        ld_valid    = 1'b0;
        ld_deferred = 1'b0;
        st_valid    = 1'b0;
        chk_valid   = 1'b0;
        chk_clear   = 1'b0;
    endtask

    task automatic set_ld(input logic [REG_W-1:0] r, input logic [ADDR_W-1:0] a,
                          input logic [1:0] s, input logic def);
        ld_valid    = 1'b1;
        ld_deferred = def;
        ld_reg      = r;
        ld_addr     = a;
        ld_size     = s;
    endtask

    task automatic set_st(input logic [ADDR_W-1:0] a, input logic [1:0] s);
        st_valid = 1'b1;
        st_addr  = a;
        st_size  = s;
    endtask

    // Driver: issue a check and push its expected response
    task automatic set_chk(input logic [REG_W-1:0] r, input logic kind, input logic clr,
                           input logic exp_hit, input string tag);
        exp_t e;
        chk_valid = 1'b1;
        chk_reg   = r;
        chk_kind  = kind;
        chk_clear = clr;
        e.hit = exp_hit;
        e.rec = !exp_hit && kind;
        e.rel = !exp_hit && !kind;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic do_ld(input logic [REG_W-1:0] r, input logic [ADDR_W-1:0] a,
                         input logic [1:0] s, input logic def);
        set_ld(r, a, s, def);
        step();
    endtask

    task automatic do_st(input logic [ADDR_W-1:0] a, input logic [1:0] s);
        set_st(a, s);
        step();
    endtask

    task automatic do_chk(input logic [REG_W-1:0] r, input logic kind, input logic clr,
                          input logic exp_hit, input string tag);
        set_chk(r, kind, clr, exp_hit, tag);
        step();
    endtask

    // Monitor: pop and compare each response
    always @(negedge clk) begin
        if (rst_n && !finished && chk_done) begin
            n_checks++;
            if (sb.size() == 0) begin
                n_fails++;
                $display("FAIL R12: response with nothing expected, actual done=1 expected done=0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (chk_hit !== e.hit || recover_req !== e.rec || reload_req !== e.rel) begin
                    n_fails++;
                    $display("FAIL %s: actual hit/rec/rel=%b%b%b expected %b%b%b",
                             e.tag, chk_hit, recover_req, reload_req, e.hit, e.rec, e.rel);
                end
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual run still busy, expected finished");
        finish_run();
    end

    initial begin
        rst_n       = 1'b0;
        flush_all   = 1'b0;
        ld_valid    = 1'b0;
        ld_deferred = 1'b0;
        ld_reg      = '0;
        ld_addr     = '0;
        ld_size     = '0;
        st_valid    = 1'b0;
        st_addr     = '0;
        st_size     = '0;
        chk_valid   = 1'b0;
        chk_reg     = '0;
        chk_kind    = 1'b0;
        chk_clear   = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();

        // R1: reset state of outputs
        n_checks++;
        if ({chk_done, chk_hit, recover_req, reload_req} !== 4'b0000) begin
            n_fails++;
            $display("FAIL R1: actual outputs=%b expected 0000",
                     {chk_done, chk_hit, recover_req, reload_req});
        end
        do_chk(7'd5, 1'b1, 1'b0, 1'b0, "R1 empty after reset");

        // R12: no check, no done
        step();
        n_checks++;
        if (chk_done !== 1'b0) begin
            n_fails++;
            $display("FAIL R12: actual done=%b expected 0 on idle cycle", chk_done);
        end

        // R2 / R6: allocate, non-clearing checks hit twice
        do_ld(7'd5, 32'h100, 2'd3, 1'b0);
        do_chk(7'd5, 1'b1, 1'b0, 1'b1, "R2 hit after load");
        do_chk(7'd5, 1'b0, 1'b0, 1'b1, "R6 non-clear keeps entry");

        // R4: store on first byte past 0x100..0x107
        do_st(32'h108, 2'd0);
        do_chk(7'd5, 1'b1, 1'b0, 1'b1, "R4 adjacent store no kill");

        // R3: two-byte store 0xFF..0x100 overlaps one byte
        do_st(32'h0FF, 2'd1);
        do_chk(7'd5, 1'b1, 1'b0, 1'b0, "R3 overlap kills, R5 recover");
        do_chk(7'd5, 1'b0, 1'b0, 1'b0, "R5 reload form miss");

        // R6: clearing check hits then entry gone
        do_ld(7'd6, 32'h200, 2'd2, 1'b0);
        do_chk(7'd6, 1'b0, 1'b1, 1'b1, "R6 clearing check hits");
        do_chk(7'd6, 1'b0, 1'b0, 1'b0, "R6 entry cleared");

        // R7: overwrite moves the address
        do_ld(7'd7, 32'h300, 2'd0, 1'b0);
        do_ld(7'd7, 32'h400, 2'd0, 1'b0);
        do_st(32'h300, 2'd0);
        do_chk(7'd7, 1'b1, 1'b0, 1'b1, "R7 old address no longer tracked");
        do_st(32'h400, 2'd0);
        do_chk(7'd7, 1'b1, 1'b0, 1'b0, "R7 new address tracked");

        // R9: store and check in one cycle
        do_ld(7'd8, 32'h500, 2'd3, 1'b0);
        set_st(32'h504, 2'd0);
        set_chk(7'd8, 1'b1, 1'b0, 1'b0, "R9 store applied before check");
        step();

        // R10: deferred loads inert
        do_ld(7'd9, 32'h580, 2'd0, 1'b1);
        do_chk(7'd9, 1'b1, 1'b0, 1'b0, "R10 deferred makes no entry");
        do_ld(7'd10, 32'h600, 2'd0, 1'b0);
        do_ld(7'd10, 32'h700, 2'd0, 1'b1);
        do_st(32'h700, 2'd0);
        do_chk(7'd10, 1'b1, 1'b0, 1'b1, "R10 deferred keeps old address");

        // R11: flush
        do_ld(7'd11, 32'h800, 2'd0, 1'b0);
        do_ld(7'd12, 32'h900, 2'd0, 1'b0);
        flush_all = 1'b1;
        step();
        do_chk(7'd11, 1'b1, 1'b0, 1'b0, "R11 flushed entry a");
        do_chk(7'd12, 1'b0, 1'b0, 1'b0, "R11 flushed entry b");
        do_ld(7'd13, 32'hA00, 2'd0, 1'b0);
        flush_all = 1'b1;
        set_chk(7'd13, 1'b1, 1'b0, 1'b0, "R11 check with flush misses");
        step();
        flush_all = 1'b1;
        set_ld(7'd14, 32'hB00, 2'd0, 1'b0);
        step();
        do_chk(7'd14, 1'b1, 1'b0, 1'b0, "R11 load with flush dropped");

        // R8: fill all slots, then two victims in order
        flush_all = 1'b1;
        step();
        for (int k = 0; k < 16; k++) begin
            do_ld(REG_W'(20 + k), 32'h1000 + 32'(k * 16), 2'd0, 1'b0);
        end
        do_ld(7'd40, 32'h2000, 2'd0, 1'b0);
        do_ld(7'd41, 32'h2010, 2'd0, 1'b0);
        do_chk(7'd20, 1'b1, 1'b0, 1'b0, "R8 first victim slot 0");
        do_chk(7'd21, 1'b1, 1'b0, 1'b0, "R8 second victim slot 1");
        do_chk(7'd22, 1'b1, 1'b0, 1'b1, "R8 slot 2 untouched");
        do_chk(7'd35, 1'b1, 1'b0, 1'b1, "R8 last slot untouched");
        do_chk(7'd40, 1'b0, 1'b0, 1'b1, "R8 new entry a");
        do_chk(7'd41, 1'b0, 1'b0, 1'b1, "R8 new entry b");

        repeat (3) step();
        n_checks++;
        if (sb.size() != 0) begin
            n_fails++;
            $display("FAIL R12: actual %0d responses missing, expected 0", sb.size());
        end
        finish_run();
    end

endmodule